// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

A single-port synchronous static memory whose read and write paths are pipelined so that a read and a write can follow each other on consecutive clocks with no idle bus cycle in between. A read returns data one clock after the edge that captured its address. A write takes its data and byte-lane enables two active clocks after its address and command. Since the read result and the write data fall in different cycles, a mixed stream of commands keeps the data buses busy on every clock.

A command starts when clock enable is asserted, load is selected and all three chip selects are active. A command with the advance strobe set continues the previous burst and its kind, using an internal 2-bit beat counter. The counter steps in linear or interleaved order. Clock enable held inactive freezes the whole block. An asynchronous sleep input quiets the block after a two-clock delay. An asynchronous output enable gates the output-valid flag. The bidirectional data pins are split into a write bus, a read bus and a valid flag.

Top module: `nt_sram`

## Requirements
- R1: A command is taken at a rising edge only with `cke_ni`=0, `adv_i`=0 and `cs1_ni`=0, `cs2_i`=1, `cs3_ni`=0. `we_ni`=1 makes it a read and `we_ni`=0 a write. If any select is inactive, the command is a deselect and causes no write and no read.
- R2: The read result for an address captured at active edge k appears on `rdata_o` with `rvalid_o`=1 after active edge k+1.
- R3: A write captured at active edge k stores the `wdata_i` value that is present at active edge k+2 (the second later edge with `cke_ni`=0).
- R4: While `cke_ni`=1, all inputs except `oe_ni` and `sleep_i` are ignored, and every pipeline stage, the burst counter and the output register hold their values.
- R5: `adv_i`=1 with `cke_ni`=0 repeats the previous command kind (read, write or deselect) at the next burst address. A continue that follows a deselect stays a deselect.
- R6: `addr_i[1:0]` seeds the beat counter and the upper address bits stay fixed during the burst. With `burst_ilv_i`=0 the low bits go seed, seed+1, seed+2, seed+3 modulo 4, then wrap.
- R7: With `burst_ilv_i`=1 the low bits go seed XOR 0, 1, 2, 3, then wrap.
- R8: `bw_ni[b]`=0 writes byte lane b (bits 8b+7..8b). Lanes with `bw_ni[b]`=1 keep their old contents, and all ones is a write abort.
- R9: After `sleep_i` has been high at two edges, new commands and write data are ignored and `rvalid_o` is 0. Memory contents are kept. Normal operation returns two edges after `sleep_i` falls.
- R10: A read of an address whose write is still pending returns the newest written bytes, forwarded lane by lane.
- R11: A deselect issued after writes does not cancel them: they complete with the data presented on the following active edges.
- R12: `rvalid_o` is 1 exactly when `oe_ni`=0, sleep is not in effect and the output register holds a read result. It is 0 after reset, and `rdata_o` is zero while `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| adv_i | input | 1 | 1 = continue burst, 0 = load new command |
| we_ni | input | 1 | Write enable, active low |
| bw_ni | input | NB | Byte-lane write enables, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| burst_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| addr_i | input | AW | Word address |
| wdata_i | input | NB*BW | Write data |
| rdata_o | output | NB*BW | Read data |
| rvalid_o | output | 1 | Read data valid / drive flag |

## Verification
A read result is due on the first negative clock edge after the next active rising edge following its capture. Write data is consumed at the second active rising edge after the write command. The sleep state changes two rising edges after `sleep_i` changes. The reference model counts only edges with clock enable low. It keeps a queue of pending writes that each carry a countdown of active edges. It commits a due write before it forms the read result at the same edge, which is how forwarding is modelled. Write data changes on every cycle, so any error of one cycle in the write delay or the read delay shows up as a data mismatch. Outputs are compared at every falling edge, half a cycle after the rising edge that updated them, using the current level of `oe_ni`.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  typedef enum logic [1:0] {
    OP_DES = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;
endpackage

// File: rtl/nt_sleep_sync.sv
module nt_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic sleep_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], sleep_i};
  end

  assign sleep_o = sync_q[STAGES-1];
endmodule

// File: rtl/nt_burst_ctrl.sv
module nt_burst_ctrl
  import nt_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sleep_i,
  input  logic          adv_i,
  input  logic          sel_i,
  input  logic          we_ni,
  input  logic          ilv_i,
  input  logic [AW-1:0] addr_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o
);
  op_e            op_q;
  logic [AW-3:0]  hi_q;
  logic [1:0]     seed_q, cnt_q, lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_DES;
      hi_q   <= '0;
      seed_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (sleep_i) begin
        op_q <= OP_DES;
      end else if (!adv_i) begin
        op_q   <= !sel_i ? OP_DES : (we_ni ? OP_RD : OP_WR);
        hi_q   <= addr_i[AW-1:2];
        seed_q <= addr_i[1:0];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign lo     = ilv_i ? (seed_q ^ cnt_q) : (seed_q + cnt_q);
  assign op_o   = op_q;
  assign addr_o = {hi_q, lo};
endmodule

// File: rtl/nt_store.sv
module nt_store #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [NB-1:0]    wbe_i,
  input  logic [NB*BW-1:0] wd_i,
  input  logic [AW-1:0]    ra_i,
  output logic [NB*BW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (wbe_i[b]) mem[wa_i][b*BW +: BW] <= wd_i[b*BW +: BW];
      end
    end
  end

  assign rd_o = mem[ra_i];
endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_ni,
  input  logic             adv_i,
  input  logic             we_ni,
  input  logic [NB-1:0]    bw_ni,
  input  logic             cs1_ni,
  input  logic             cs2_i,
  input  logic             cs3_ni,
  input  logic             oe_ni,
  input  logic             burst_ilv_i,
  input  logic             sleep_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB*BW-1:0] wdata_i,
  output logic [NB*BW-1:0] rdata_o,
  output logic             rvalid_o
);
  localparam int DW = NB * BW;

  logic          en, sel, sleep_eff;
  op_e           cur_op;
  logic [AW-1:0] cur_addr;
  logic          wr_vld_q;
  logic [AW-1:0] wr_addr_q;
  logic          commit, fwd_hit;
  logic [NB-1:0] wbe;
  logic [DW-1:0] arr_rd, merged;
  logic          out_vld_q;
  logic [DW-1:0] out_q;

  assign en  = ~cke_ni;
  assign sel = ~cs1_ni & cs2_i & ~cs3_ni;

  nt_sleep_sync #(.STAGES(2)) i_sleep (
    .clk_i, .rst_ni, .sleep_i, .sleep_o(sleep_eff)
  );

  nt_burst_ctrl #(.AW(AW)) i_burst (
    .clk_i, .rst_ni,
    .en_i(en), .sleep_i(sleep_eff), .adv_i, .sel_i(sel), .we_ni,
    .ilv_i(burst_ilv_i), .addr_i, .op_o(cur_op), .addr_o(cur_addr)
  );

  // delayed-write stage: data arrives one active edge after this register loads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_q  <= 1'b0;
      wr_addr_q <= '0;
    end else if (en) begin
      wr_vld_q  <= (cur_op == OP_WR);
      wr_addr_q <= cur_addr;
    end
  end

  assign commit = en & wr_vld_q & ~sleep_eff;
  assign wbe    = ~bw_ni;

  nt_store #(.AW(AW), .NB(NB), .BW(BW)) i_store (
    .clk_i, .we_i(commit), .wa_i(wr_addr_q), .wbe_i(wbe), .wd_i(wdata_i),
    .ra_i(cur_addr), .rd_o(arr_rd)
  );

  assign fwd_hit = commit & (wr_addr_q == cur_addr);

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign merged[b*BW +: BW] = (fwd_hit & wbe[b]) ? wdata_i[b*BW +: BW]
                                                   : arr_rd[b*BW +: BW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else if (en) begin
      out_vld_q <= (cur_op == OP_RD);
      if (cur_op == OP_RD) out_q <= merged;
    end
  end

  assign rvalid_o = ~oe_ni & ~sleep_eff & out_vld_q;
  assign rdata_o  = rvalid_o ? out_q : '0;
endmodule

// File: rtl/nt_sram_chk.sv
module nt_sram_chk
  import nt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cke_ni,
  input logic          adv_i,
  input logic          we_ni,
  input logic          sel,
  input logic          burst_ilv_i,
  input logic          sleep_i,
  input logic          sleep_eff,
  input op_e           cur_op,
  input logic [AW-1:0] cur_addr,
  input logic          out_vld_q,
  input logic [DW-1:0] out_q,
  input logic          rvalid_o
);
  AST_LOAD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && sel && we_ni && !sleep_eff) |=> cur_op == OP_RD); // R1

  AST_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && !sel) |=> cur_op == OP_DES); // R1

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && cur_op == OP_RD) |=> out_vld_q); // R2

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(out_q) && $stable(out_vld_q) && $stable(cur_op)
                && $stable(cur_addr[AW-1:2]))); // R4

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_i && !burst_ilv_i && !sleep_eff)
      |=> (burst_ilv_i || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)); // R6

  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && $past(sleep_i)) |=> !rvalid_o); // R9
endmodule

bind nt_sram nt_sram_chk #(.AW(AW), .DW(NB*BW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_ni(cke_ni), .adv_i(adv_i),
  .we_ni(we_ni), .sel(sel), .burst_ilv_i(burst_ilv_i), .sleep_i(sleep_i),
  .sleep_eff(sleep_eff), .cur_op(cur_op), .cur_addr(cur_addr),
  .out_vld_q(out_vld_q), .out_q(out_q), .rvalid_o(rvalid_o)
);

// File: tb/test_nt_sram.sv
module test_nt_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cke_ni = 1'b0, adv_i = 1'b0, we_ni = 1'b1;
  logic [NB-1:0] bw_ni = '0;
  logic          cs1_ni = 1'b1, cs2_i = 1'b0, cs3_ni = 1'b1;
  logic          oe_ni = 1'b0, burst_ilv_i = 1'b0, sleep_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  nt_sram #(.AW(AW), .NB(NB), .BW(BW)) i_nt_sram (
    .clk_i, .rst_ni, .cke_ni, .adv_i, .we_ni, .bw_ni, .cs1_ni, .cs2_i,
    .cs3_ni, .oe_ni, .burst_ilv_i, .sleep_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o
  );

  always #5 clk_i = ~clk_i;

  int    total = 0, bad = 0, cyc = 0;
  bit    done = 1'b0;
  string req_tag = "R12";
  logic [NB-1:0] bw_pat = '0;

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_known [DEPTH];
  int            m_kind, m_base, m_beat, rd_addr, cur_a, lo, wa;
  bit            rd_pend, m_vld, m_dknown, m_s1, m_s2, eff;
  logic [DW-1:0] m_data;
  int            wq_addr[$];
  int            wq_due[$];

  initial for (int i = 0; i < DEPTH; i++) m_known[i] = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_kind = 0; m_base = 0; m_beat = 0; rd_pend = 0; m_vld = 0;
      m_s1 = 0; m_s2 = 0; wq_addr.delete(); wq_due.delete();
    end else begin
      eff  = m_s2;
      m_s2 = m_s1;
      m_s1 = sleep_i;
      if (!cke_ni) begin
        foreach (wq_due[i]) wq_due[i] = wq_due[i] - 1;
        if (wq_due.size() > 0 && wq_due[0] == 0) begin
          wa = wq_addr.pop_front();
          void'(wq_due.pop_front());
          if (!eff) begin
            for (int b = 0; b < NB; b++)
              if (!bw_ni[b]) m_mem[wa][b*BW +: BW] = wdata_i[b*BW +: BW];
            if (bw_ni == '0) m_known[wa] = 1'b1;
          end
        end
        m_vld = rd_pend;
        if (rd_pend) begin
          m_data   = m_mem[rd_addr];
          m_dknown = m_known[rd_addr];
        end
        rd_pend = 0;
        if (eff) m_kind = 0;
        else if (!adv_i) begin
          m_kind = (!cs1_ni && cs2_i && !cs3_ni) ? (we_ni ? 1 : 2) : 0;
          m_base = int'(addr_i);
          m_beat = 0;
        end else m_beat = m_beat + 1;
        if (m_kind != 0) begin
          lo    = burst_ilv_i ? ((m_base & 3) ^ (m_beat & 3)) : (((m_base & 3) + m_beat) & 3);
          cur_a = (m_base & ~3) | lo;
          if (m_kind == 1) begin rd_pend = 1; rd_addr = cur_a; end
          else begin wq_addr.push_back(cur_a); wq_due.push_back(2); end
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit exp_v;
      exp_v = m_vld && !oe_ni && !m_s2;
      total++;
      if (rvalid_o !== exp_v) begin
        bad++;
        $display("FAIL %s rvalid cyc=%0d actual=%0b expected=%0b", req_tag, cyc, rvalid_o, exp_v);
      end
      if (exp_v && m_dknown) begin
        total++;
        if (rdata_o !== m_data) begin
          bad++;
          $display("FAIL %s rdata cyc=%0d actual=%h expected=%h", req_tag, cyc, rdata_o, m_data);
        end
      end else if (!exp_v) begin
        total++;
        if (rdata_o !== '0) begin
          bad++;
          $display("FAIL R12 idle rdata cyc=%0d actual=%h expected=0", cyc, rdata_o);
        end
      end
    end
  end

  // sc: 0 all selects active, 1/2/3 the matching select inactive
  task automatic step(input bit ck, input bit ad, input bit wn, input int sc, input int a);
    @(negedge clk_i);
    #1;
    cke_ni = ck; adv_i = ad; we_ni = wn;
    cs1_ni = (sc == 1); cs2_i = (sc != 2); cs3_ni = (sc == 3);
    addr_i = AW'(a);
    cyc++;
    wdata_i = DW'(cyc) * 32'h9E3779B1 ^ (DW'(cyc) << 7);
    bw_ni = bw_pat;
  endtask

  task automatic wr(input int a);   step(0, 0, 0, 0, a); endtask
  task automatic rd(input int a);   step(0, 0, 1, 0, a); endtask
  task automatic cont();            step(0, 1, 1, 0, 0); endtask
  task automatic des(input int n);  for (int i = 0; i < n; i++) step(0, 0, 1, 1, 0); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;

    req_tag = "R12";               // reset state: no valid read
    des(2);

    req_tag = "R3";                // fill, data taken two active edges later
    for (int a = 0; a < 32; a++) wr(a);
    des(3);

    req_tag = "R2";                // back-to-back reads
    for (int a = 0; a < 32; a++) rd(a);
    req_tag = "R12";
    oe_ni = 1'b1;
    for (int a = 0; a < 4; a++) rd(a);
    oe_ni = 1'b0;
    des(3);

    req_tag = "R10";               // write followed at once by read of same word
    for (int i = 0; i < 8; i++) begin wr(40 + i); rd(40 + i); end
    wr(30); des(1); rd(30);
    des(3);

    req_tag = "R4";                // stalls in the middle of the pipeline
    wr(8);
    step(1, 0, 0, 0, 9); step(1, 0, 0, 0, 9);
    rd(8);
    step(1, 0, 0, 0, 10); step(1, 1, 0, 0, 10);
    rd(9);
    step(1, 0, 0, 0, 11);
    des(3);

    req_tag = "R6";                // linear burst with wrap
    burst_ilv_i = 1'b0;
    wr(22); step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    rd(21); cont(); cont(); cont(); cont();
    req_tag = "R5";                // continue after deselect stays deselect
    des(1); step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    rd(20); rd(21); rd(22); rd(23);
    des(3);

    req_tag = "R7";                // interleaved burst
    burst_ilv_i = 1'b1;
    des(2);
    wr(49); step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    rd(50); cont(); cont(); cont(); cont();
    des(2);
    burst_ilv_i = 1'b0;
    des(2);

    req_tag = "R8";                // byte lanes and abort
    bw_pat = 4'b1010; wr(5); des(2);
    bw_pat = 4'b1111; wr(6); des(2);
    bw_pat = 4'b0110; wr(7); des(2);
    bw_pat = 4'b0000; des(1);
    rd(5); rd(6); rd(7);
    des(3);

    req_tag = "R11";               // deselect right after writes
    wr(10); wr(11); step(0, 0, 0, 2, 12); step(0, 1, 0, 0, 0);
    rd(10); rd(11); rd(12);
    des(3);

    req_tag = "R1";                // partial selects cause no write
    wr(13); des(3);
    step(0, 0, 0, 1, 13); step(0, 0, 0, 2, 14); step(0, 0, 0, 3, 15);
    des(3);
    rd(13); rd(14); rd(15);
    des(3);

    req_tag = "R9";                // sleep: commands ignored, output quiet
    sleep_i = 1'b1;
    for (int a = 0; a < 6; a++) rd(a);
    wr(0); wr(1); des(2);
    sleep_i = 1'b0;
    des(2);
    rd(0); rd(1); rd(2);
    des(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog %s actual=running expected=finished", req_tag);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule